// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation cache after a miss. A miss request carries a 32-bit virtual address. The walker splits that address into a 10-bit top-level index (bits 31..22), a 10-bit second-level index (bits 21..12) and a 12-bit page offset (bits 11..0). It then makes two dependent reads through a simple read port:

- The first read fetches the top-level entry. That entry names the page that holds the second-level table.
- The second read fetches the leaf entry. The leaf entry gives the frame number and the status bits that go into the translation cache.

The top-level table is found through a root page number that is held on an input port. The table format in memory is fixed. If either entry is marked not present, the walk ends in a page fault that reports the faulting virtual address. A fault found at the top level ends the walk without issuing the second read.

Only one walk runs at a time. A new request is taken only while the walker is idle. The result, success or fault, stays on the outputs until the requester acknowledges it. The memory port may stall its request acceptance, and it may delay its response, for any number of cycles.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and both `mem_req_valid` and `res_valid` are 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the result is acknowledged. Requests offered during that time are ignored, and the result that follows belongs to the first address.
- R3: The first read address equals `{root_pfn, 12'h000}` plus four times vaddr[31:22].
- R4: The second read address equals the top-level entry's bits 31..12 shifted left by 12, plus four times vaddr[21:12].
- R5: If the top-level entry has bit 0 (present) clear, the walk ends with `res_fault`=1, `fault_vaddr` equal to the request address, and exactly one memory read.
- R6: If the leaf entry has bit 0 clear, the walk ends with `res_fault`=1 and `fault_vaddr` equal to the request address, after two reads.
- R7: On success, `res_fault`=0, `res_frame` equals leaf bits 31..12, and `res_flags` equals leaf bits 4..1. In `res_flags`, bit 0 is W, bit 1 is R, bit 2 is D and bit 3 is V.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted and `mem_req_addr` does not change.
- R9: While `res_valid` is 1 and `res_ack` is 0, all result outputs stay unchanged. After an edge with `res_ack` high, `res_valid` is 0 and `req_ready` is 1.
- R10: After a read is accepted, no further read is requested until its response has arrived, however long the response takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_pfn | input | 20 | Page number of the top-level table |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Missing virtual address |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read |
| res_valid | output | 1 | Walk result available |
| res_fault | output | 1 | Walk ended in a page fault |
| res_frame | output | 20 | Frame number of the leaf entry |
| res_flags | output | 4 | Status bits {V,D,R,W} of the leaf entry |
| fault_vaddr | output | 32 | Virtual address of the walk |
| res_ack | input | 1 | Requester consumes the result |

## Verification
A request accepted at one rising edge makes `req_ready` fall and `mem_req_valid` rise before the next falling edge. The bench samples both at that falling edge. The result appears in the cycle after the edge that accepts the last response; this is one response after an early fault and two otherwise. Because the memory model adds stall and latency cycles that vary by test, the bench waits for `res_valid` at falling edges within a bounded window. It then checks the number of reads and each logged address, not a fixed cycle count. Holding of the result is checked over three unacknowledged cycles, and release is checked one edge after the acknowledge.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_L1,
    ST_WT_L1,
    ST_RD_L2,
    ST_WT_L2,
    ST_DONE,
    ST_FAULT
  } walk_st_e;

  localparam int PRESENT_BIT = 0;
  localparam int FLAG_LSB    = 1;

endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int LEVELS = 2,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  localparam int VA_W  = OFF_W + LEVELS * IDX_W
) (
  input  logic [VA_W-1:0]              va,
  output logic [LEVELS-1:0][IDX_W-1:0] idx
);

  // Level 0 is the top level and takes the highest index field.
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    assign idx[l] = va[OFF_W + (LEVELS - 1 - l) * IDX_W +: IDX_W];
  end

  logic [OFF_W-1:0] unused_off;
  assign unused_off = va[OFF_W-1:0];

endmodule

// File: rtl/pt_addr_calc.sv
module pt_addr_calc #(
  parameter int VA_W      = 32,
  parameter int IDX_W     = 10,
  parameter int OFF_W     = 12,
  parameter int ENT_BYTES = 4,
  localparam int PFN_W    = VA_W - OFF_W,
  localparam int ESH      = $clog2(ENT_BYTES)
) (
  input  logic [PFN_W-1:0] base_pfn,
  input  logic [IDX_W-1:0] idx,
  output logic [VA_W-1:0]  addr
);

  logic [VA_W-1:0] base_b;
  logic [VA_W-1:0] offs_b;

  always_comb begin
    base_b = {base_pfn, {OFF_W{1'b0}}};
    offs_b = VA_W'({idx, {ESH{1'b0}}});
    addr   = base_b + offs_b;
  end

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int PTE_W  = 32,
  parameter int FLAG_W = 4,
  localparam int PFN_W = VA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  input  logic              res_ack,
  output logic              res_valid,
  output logic              res_fault,
  output logic              lvl2_sel,
  output logic [VA_W-1:0]   va_q,
  output logic [PFN_W-1:0]  l2_pfn_q,
  output logic [PFN_W-1:0]  leaf_pfn_q,
  output logic [FLAG_W-1:0] leaf_flags_q
);

  walk_st_e state_q, state_d;
  logic     va_en, l2_en, leaf_en;
  logic     rsp_present;

  assign rsp_present = mem_rsp_data[PRESENT_BIT];

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid)     state_d = ST_RD_L1;
      ST_RD_L1: if (mem_req_ready) state_d = ST_WT_L1;
      ST_WT_L1: if (mem_rsp_valid) state_d = rsp_present ? ST_RD_L2 : ST_FAULT;
      ST_RD_L2: if (mem_req_ready) state_d = ST_WT_L2;
      ST_WT_L2: if (mem_rsp_valid) state_d = rsp_present ? ST_DONE : ST_FAULT;
      ST_DONE,
      ST_FAULT: if (res_ack)       state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  assign va_en   = (state_q == ST_IDLE)  && req_valid;
  assign l2_en   = (state_q == ST_WT_L1) && mem_rsp_valid;
  assign leaf_en = (state_q == ST_WT_L2) && mem_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      va_q         <= '0;
      l2_pfn_q     <= '0;
      leaf_pfn_q   <= '0;
      leaf_flags_q <= '0;
    end else begin
      state_q <= state_d;
      if (va_en)   va_q         <= req_vaddr;
      if (l2_en)   l2_pfn_q     <= mem_rsp_data[PTE_W-1 -: PFN_W];
      if (leaf_en) leaf_pfn_q   <= mem_rsp_data[PTE_W-1 -: PFN_W];
      if (leaf_en) leaf_flags_q <= mem_rsp_data[FLAG_LSB +: FLAG_W];
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_RD_L1) || (state_q == ST_RD_L2);
  assign lvl2_sel      = (state_q == ST_RD_L2);
  assign res_valid     = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign res_fault     = (state_q == ST_FAULT);

  logic [PTE_W-PFN_W-FLAG_W-2:0] unused_rsp_bits;
  assign unused_rsp_bits = mem_rsp_data[PTE_W-PFN_W-1:FLAG_LSB+FLAG_W];

  AST_BUSY_VA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(va_q)); // R2

  AST_L1_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WT_L1 && mem_rsp_valid && !rsp_present) |=> (res_valid && res_fault)); // R5

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W     = 10,
  parameter int OFF_W     = 12,
  parameter int ENT_BYTES = 4,
  parameter int FLAG_W    = 4,
  localparam int LEVELS   = 2,
  localparam int VA_W     = OFF_W + LEVELS * IDX_W,
  localparam int PFN_W    = VA_W - OFF_W,
  localparam int PTE_W    = ENT_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PFN_W-1:0]  root_pfn,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [VA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              res_valid,
  output logic              res_fault,
  output logic [PFN_W-1:0]  res_frame,
  output logic [FLAG_W-1:0] res_flags,
  output logic [VA_W-1:0]   fault_vaddr,
  input  logic              res_ack
);

  logic                        lvl2_sel;
  logic [VA_W-1:0]             va_q;
  logic [PFN_W-1:0]            l2_pfn_q;
  logic [LEVELS-1:0][IDX_W-1:0] idx;
  logic [PFN_W-1:0]            sel_pfn;
  logic [IDX_W-1:0]            sel_idx;

  pt_walk_ctrl #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PTE_W(PTE_W), .FLAG_W(FLAG_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_ack(res_ack), .res_valid(res_valid), .res_fault(res_fault),
    .lvl2_sel(lvl2_sel), .va_q(va_q), .l2_pfn_q(l2_pfn_q),
    .leaf_pfn_q(res_frame), .leaf_flags_q(res_flags)
  );

  pt_va_split #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) u_split (
    .va(va_q), .idx(idx)
  );

  assign sel_pfn = lvl2_sel ? l2_pfn_q : root_pfn;
  assign sel_idx = lvl2_sel ? idx[1]   : idx[0];

  pt_addr_calc #(
    .VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENT_BYTES(ENT_BYTES)
  ) u_addr (
    .base_pfn(sel_pfn), .idx(sel_idx), .addr(mem_req_addr)
  );

  assign fault_vaddr = va_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !res_valid)); // R1

  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R8

  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R10

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ack) |=> (res_valid && $stable(res_fault) && $stable(res_frame)
                                 && $stable(res_flags) && $stable(fault_vaddr))); // R9

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] root_pfn;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        res_valid, res_fault;
  logic [19:0] res_frame;
  logic [3:0]  res_flags;
  logic [31:0] fault_vaddr;
  logic        res_ack;

  int n_chk = 0;
  int n_err = 0;
  int req_stall = 0;
  int rsp_lat = 0;
  int n_rd = 0;
  logic [31:0] addr_log [4];
  logic [31:0] mem [4096];

  always #5 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .root_pfn(root_pfn),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
    .res_frame(res_frame), .res_flags(res_flags), .fault_vaddr(fault_vaddr),
    .res_ack(res_ack)
  );

  function automatic int midx(input logic [31:0] a);
    return int'({a[13:12], a[11:2]});
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Memory model: serves one read at a time with programmable stall and latency.
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [31:0] a;
        a = mem_req_addr;
        for (int s = 0; s < req_stall; s++) begin
          @(negedge clk);
          chk(mem_req_valid && mem_req_addr == a, "R8 request held", mem_req_addr, a);
        end
        mem_req_ready = 1'b1;
        if (n_rd < 4) addr_log[n_rd] = a;
        n_rd++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int s = 0; s < rsp_lat; s++) begin
          chk(!mem_req_valid, "R10 no second read", 32'(mem_req_valid), 32'h0);
          @(negedge clk);
        end
        chk(!mem_req_valid, "R10 no second read", 32'(mem_req_valid), 32'h0);
        mem_rsp_data  = mem[midx(a)];
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic run_walk(input logic [31:0] va, input int stall, input int lat,
                          input bit exp_fault, input int exp_reads,
                          input logic [31:0] a1, input logic [31:0] a2,
                          input logic [19:0] frame, input logic [3:0] flags,
                          input bit poke_busy);
    logic [31:0] h_frame, h_va;
    logic [3:0]  h_flags;
    logic        h_fault;
    req_stall = stall;
    rsp_lat   = lat;
    n_rd      = 0;
    @(negedge clk);
    chk(req_ready, "R2 ready when idle", 32'(req_ready), 32'h1);
    req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 busy after accept", 32'(req_ready), 32'h0);
    chk(mem_req_valid, "R3 first read issued", 32'(mem_req_valid), 32'h1);
    if (poke_busy) begin
      req_vaddr = ~va;
      req_valid = 1'b1;
    end
    for (int i = 0; i < 400 && !res_valid; i++) @(negedge clk);
    req_valid = 1'b0;
    chk(res_valid, "R7 result arrives", 32'(res_valid), 32'h1);
    chk(res_fault == exp_fault, exp_fault ? (exp_reads == 1 ? "R5 fault" : "R6 fault") : "R7 no fault",
        32'(res_fault), 32'(exp_fault));
    chk(n_rd == exp_reads, exp_reads == 1 ? "R5 read count" : "R4 read count", 32'(n_rd), 32'(exp_reads));
    chk(addr_log[0] == a1, "R3 top entry address", addr_log[0], a1);
    if (exp_reads == 2) chk(addr_log[1] == a2, "R4 leaf entry address", addr_log[1], a2);
    if (exp_fault) begin
      chk(fault_vaddr == va, exp_reads == 1 ? "R5 fault address" : "R6 fault address", fault_vaddr, va);
    end else begin
      chk(res_frame == frame, "R7 frame", 32'(res_frame), 32'(frame));
      chk(res_flags == flags, "R7 flags", 32'(res_flags), 32'(flags));
      if (poke_busy) chk(fault_vaddr == va, "R2 first address kept", fault_vaddr, va);
    end
    h_frame = 32'(res_frame);
    h_flags = res_flags;
    h_fault = res_fault;
    h_va    = fault_vaddr;
    repeat (3) @(negedge clk);
    chk(res_valid && res_fault == h_fault && 32'(res_frame) == h_frame &&
        res_flags == h_flags && fault_vaddr == h_va, "R9 result held", fault_vaddr, h_va);
    res_ack = 1'b1;
    @(negedge clk);
    res_ack = 1'b0;
    chk(!res_valid && req_ready, "R9 release on ack", {30'h0, res_valid, req_ready}, 32'h1);
  endtask

  bit finished = 1'b0;

  initial begin
    for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    // Root table at page 0x00031, second-level tables at 0x00052 and 0x77773.
    mem[midx(32'h0003_1014)] = 32'h0005_2001;
    mem[midx(32'h0003_101C)] = 32'h0009_9000;
    mem[midx(32'h0003_1024)] = 32'h7777_3001;
    mem[midx(32'h0003_1FFC)] = 32'h0005_2001;
    mem[midx(32'h0005_20E8)] = 32'hABCD_E017;
    mem[midx(32'h7777_3FFC)] = 32'h1234_5016;
    mem[midx(32'h0005_2000)] = 32'hFFFF_F01F;
    root_pfn  = 20'h00031;
    req_valid = 1'b0;
    req_vaddr = '0;
    res_ack   = 1'b0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req_valid && !res_valid, "R1 reset state",
        {29'h0, req_ready, mem_req_valid, res_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !res_valid, "R1 after release",
        {29'h0, req_ready, mem_req_valid, res_valid}, 32'h4);

    // R7: normal two-read walk, no stalls
    run_walk(32'h0143_A123, 0, 0, 1'b0, 2, 32'h0003_1014, 32'h0005_20E8, 20'hABCDE, 4'hB, 1'b0);
    // R5: top-level entry absent, one read only
    run_walk(32'h01C5_5ABC, 1, 2, 1'b1, 1, 32'h0003_101C, 32'h0, 20'h0, 4'h0, 1'b0);
    // R6: leaf absent at the highest second-level index
    run_walk(32'h027F_FFFF, 0, 1, 1'b1, 2, 32'h0003_1024, 32'h7777_3FFC, 20'h0, 4'h0, 1'b0);
    // R8/R10: highest top-level index, stalled port, long latency, all flags set
    run_walk(32'hFFC0_0007, 3, 5, 1'b0, 2, 32'h0003_1FFC, 32'h0005_2000, 20'hFFFFF, 4'hF, 1'b0);
    // R2: requests offered while busy are ignored
    run_walk(32'h0143_A123, 2, 3, 1'b0, 2, 32'h0003_1014, 32'h0005_20E8, 20'hABCDE, 4'hB, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule